// File: doc/BRIEF.md
# Scoreboard Out-of-Order Issue Controller

This block schedules instructions for five execution units without renaming any register. The units are one integer ALU, one load unit, one store unit and two pipelined floating-point units. Decoded instructions arrive in program order, one per cycle. Each carries a unit class, an optional destination register and up to two source registers. The controller books a unit for each accepted instruction and records which unit will produce each register. It then lets instructions start as soon as their operands exist, which may be out of program order. The register file and the unit datapaths sit outside the block. The controller only produces the control strobes: dispatch stall, issue grant, execute start and writeback enable.

Each unit moves through four phases: waiting for operands, executing, finished, and freed. Read-after-write dependences delay issue. Write-after-write dependences and a busy unit delay dispatch. Write-after-read dependences delay writeback. Execute time comes from a counter in each unit: one cycle for the ALU, load and store units, and a parameter (default three) for the floating-point units. Only one instruction is granted per cycle, and the one dispatched earliest wins.

Top module: `ooo_scoreboard`

## Requirements
- R1: After reset no unit is busy and no register has a pending producer: grant, execute-start and writeback outputs are all zero. A first instruction is accepted in the cycle it is presented and is granted in the next cycle.
- R2: The class codes are 0 ALU, 1 load, 2 store and 3 floating point. A class-3 instruction may take any free floating-point unit. `in_stall` is high while `in_valid` is high and no unit of the presented class is free.
- R3: `in_stall` is high while the presented destination register still has a producer that has not written back (write-after-write).
- R4: An accepted instruction records, for each source it uses, the unit that will produce that source. It is granted in a cycle when both used sources are available, and no earlier than the cycle after dispatch. Its execute-start pulse comes one cycle after the grant.
- R5: A finished unit does not write back while any instruction that is not yet granted still reads the unit's destination register as an already-available value (write-after-read). It writes back in the cycle after that reader is granted.
- R6: A grant may occur in the same cycle as the writeback of the unit that produces one of its sources.
- R7: A unit freed by a writeback, and a destination register released by that writeback, may be used by a dispatch in the same cycle.
- R8: At most one grant is given per cycle. When several waiting instructions are ready, the one accepted earliest is granted, whatever the unit index.
- R9: ALU, load and store units execute for one cycle and floating-point units for FP_LAT cycles. Writeback can come no earlier than the cycle after the last execute cycle. Instructions with no destination never wait at writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A decoded instruction is presented |
| in_cls | input | 2 | Unit class: 0 ALU, 1 load, 2 store, 3 floating point |
| in_dst_en | input | 1 | Instruction writes a destination register |
| in_dst | input | REG_W | Destination register number |
| in_s1_en | input | 1 | First source is used |
| in_s1 | input | REG_W | First source register number |
| in_s2_en | input | 1 | Second source is used |
| in_s2 | input | REG_W | Second source register number |
| in_stall | output | 1 | Presented instruction cannot be accepted this cycle |
| in_unit | output | NU | One-hot unit booked for the accepted instruction |
| iss_grant | output | NU | One-hot: unit whose instruction reads the register file now |
| ex_start | output | NU | First execute cycle of each unit |
| wb_en | output | NU | Unit writes its result and frees its entry this cycle |

## Verification
Several properties are checked on every cycle by assertions. A grant goes only to a waiting unit and is followed by that unit's execute pulse. No more than one grant is given, and a ready unit is never left ungranted. Dispatch books only a unit that is free or is being freed, and a stall is raised only when an instruction is presented. The ordering behaviours appear only in the bench scenarios: hazard stalls, the write-after-read hold, same-cycle writeback with issue or reallocation, oldest-first choice over unit index, and the exact stage cycles of a two-iteration load, multiply, store and add loop.

// File: rtl/ooo_sb_pkg.sv
// Shared types for the scoreboard issue controller.
// Assumes the unit order ALU, load, store, then the floating-point units.
package ooo_sb_pkg;

    typedef enum logic [1:0] {
        CLS_ALU = 2'd0,
        CLS_LD  = 2'd1,
        CLS_ST  = 2'd2,
        CLS_FP  = 2'd3
    } op_cls_e;

    typedef enum logic [1:0] {
        ENT_FREE,
        ENT_WAIT,
        ENT_EXEC,
        ENT_DONE
    } ent_state_e;

    localparam int FIXED_UNITS = 3;

    // Class served by unit index idx
    function automatic op_cls_e unit_class(input int idx);
        case (idx)
            0:       return CLS_ALU;
            1:       return CLS_LD;
            2:       return CLS_ST;
            default: return CLS_FP;
        endcase
    endfunction

endpackage

// File: rtl/ooo_sb_entry.sv
// One unit status entry. It holds the register names, the producer tags of
// the sources, the dispatch age and an execute latency counter.
// Assumes alloc_i is raised only when the entry is free or writing back.
module ooo_sb_entry
    import ooo_sb_pkg::*;
#(
    parameter int REG_W  = 4,
    parameter int TAG_W  = 3,
    parameter int SEQ_W  = 4,
    parameter int NU     = 5,
    parameter int LAT    = 1,
    parameter int MY_IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_i,
    input  logic             dst_en_i,
    input  logic [REG_W-1:0] dst_i,
    input  logic             s1_en_i,
    input  logic [REG_W-1:0] s1_i,
    input  logic [TAG_W-1:0] t1_i,
    input  logic             s2_en_i,
    input  logic [REG_W-1:0] s2_i,
    input  logic [TAG_W-1:0] t2_i,
    input  logic [SEQ_W-1:0] seq_i,
    input  logic             grant_i,
    input  logic [NU-1:0]    wb_vec_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             req_o,
    output logic             exec_o,
    output logic             dst_en_o,
    output logic [REG_W-1:0] dst_o,
    output logic             rd1_o,
    output logic [REG_W-1:0] src1_o,
    output logic             rd2_o,
    output logic [REG_W-1:0] src2_o,
    output logic [SEQ_W-1:0] seq_o
);

    localparam int CNT_W = $clog2(LAT + 1);

    ent_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [TAG_W-1:0] t1_q, t2_q;
    logic             s1_en_q, s2_en_q;
    logic             t1_now, t2_now;

    // A source is available if its tag is zero or its producer writes back now
    always_comb begin
        t1_now = (t1_q == '0);
        t2_now = (t2_q == '0);
        for (int k = 0; k < NU; k++) begin
            if (wb_vec_i[k] && t1_q == TAG_W'(k + 1)) t1_now = 1'b1;
            if (wb_vec_i[k] && t2_q == TAG_W'(k + 1)) t2_now = 1'b1;
        end
    end

    // Phase sequence, tag clearing and field capture on allocation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENT_FREE;
            cnt_q   <= '0;
            t1_q    <= '0;
            t2_q    <= '0;
        end else begin
            case (state_q)
                ENT_WAIT: begin
                    if (t1_now) t1_q <= '0;
                    if (t2_now) t2_q <= '0;
                    if (grant_i) begin
                        state_q <= ENT_EXEC;
                        cnt_q   <= CNT_W'(LAT);
                    end
                end
                ENT_EXEC: begin
                    cnt_q <= cnt_q - CNT_W'(1);
                    if (cnt_q == CNT_W'(1)) state_q <= ENT_DONE;
                end
                ENT_DONE: if (wb_vec_i[MY_IDX]) state_q <= ENT_FREE;
                default: ;
            endcase
            if (alloc_i) begin
                state_q  <= ENT_WAIT;
                t1_q     <= t1_i;
                t2_q     <= t2_i;
                dst_en_o <= dst_en_i;
                dst_o    <= dst_i;
                s1_en_q  <= s1_en_i;
                src1_o   <= s1_i;
                s2_en_q  <= s2_en_i;
                src2_o   <= s2_i;
                seq_o    <= seq_i;
            end
        end
    end

    assign busy_o = (state_q != ENT_FREE);
    assign done_o = (state_q == ENT_DONE);
    assign req_o  = (state_q == ENT_WAIT) && t1_now && t2_now;
    assign exec_o = (state_q == ENT_EXEC) && (cnt_q == CNT_W'(LAT));
    assign rd1_o  = (state_q == ENT_WAIT) && s1_en_q && (t1_q == '0);
    assign rd2_o  = (state_q == ENT_WAIT) && s2_en_q && (t2_q == '0);

    // R4
    grant_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_i |-> state_q == ENT_WAIT);

    // R4
    exec_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_i |=> exec_o);

endmodule

// File: rtl/ooo_sb_select.sv
// Oldest-first issue select. It grants the ready entry with the oldest
// dispatch number. Assumes fewer than 2**(SEQ_W-1) entries are in flight,
// so the modular age difference is unambiguous.
module ooo_sb_select #(
    parameter int NU    = 5,
    parameter int SEQ_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NU-1:0]            req_i,
    input  logic [NU-1:0][SEQ_W-1:0] seq_i,
    output logic [NU-1:0]            grant_o
);

    // True when age a was dispatched before age b
    function automatic logic older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] diff;
        diff = b - a;
        return (diff != '0) && !diff[SEQ_W-1];
    endfunction

    // An entry wins when no other ready entry is older
    always_comb begin
        for (int i = 0; i < NU; i++) begin
            grant_o[i] = req_i[i];
            for (int j = 0; j < NU; j++) begin
                if (j != i && req_i[j] && older(seq_i[j], seq_i[i])) grant_o[i] = 1'b0;
            end
        end
    end

    // R8
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R8
    grant_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_i) |-> (|(grant_o & req_i)));

endmodule

// File: rtl/ooo_sb_alloc.sv
// Dispatch unit picker. It books the lowest free unit of the presented
// class and stalls on a missing unit or a pending destination producer.
// Assumes free_i already counts units that write back this cycle.
module ooo_sb_alloc
    import ooo_sb_pkg::*;
#(
    parameter int NU = 5
) (
    input  logic    valid_i,
    input  op_cls_e cls_i,
    input  logic    waw_i,
    input  logic [NU-1:0] free_i,
    output logic    stall_o,
    output logic [NU-1:0] pick_o
);

    logic found;

    // First free unit of the class, withheld while stalled
    always_comb begin
        pick_o = '0;
        found  = 1'b0;
        for (int u = 0; u < NU; u++) begin
            if (!found && free_i[u] && unit_class(u) == cls_i) begin
                pick_o[u] = 1'b1;
                found     = 1'b1;
            end
        end
        stall_o = valid_i && (!found || waw_i);
        if (!valid_i || stall_o) pick_o = '0;
    end

endmodule

// File: rtl/ooo_scoreboard.sv
// Scoreboard issue controller top. It holds the register producer table and
// the dispatch age counter, checks the write-after-read hold, and connects
// the unit entries, the picker and the select. There is no renaming and no
// bypass. Register values are read at grant and written at writeback.
module ooo_scoreboard
    import ooo_sb_pkg::*;
#(
    parameter int NREG    = 16,
    parameter int N_FP    = 2,
    parameter int FP_LAT  = 3,
    parameter int INT_LAT = 1,
    localparam int NU     = FIXED_UNITS + N_FP,
    localparam int REG_W  = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       in_cls,
    input  logic             in_dst_en,
    input  logic [REG_W-1:0] in_dst,
    input  logic             in_s1_en,
    input  logic [REG_W-1:0] in_s1,
    input  logic             in_s2_en,
    input  logic [REG_W-1:0] in_s2,
    output logic             in_stall,
    output logic [NU-1:0]    in_unit,
    output logic [NU-1:0]    iss_grant,
    output logic [NU-1:0]    ex_start,
    output logic [NU-1:0]    wb_en
);

    localparam int TAG_W = $clog2(NU + 1);
    localparam int SEQ_W = $clog2(NU) + 1;

    logic [TAG_W-1:0] rstat [NREG];
    logic [SEQ_W-1:0] seq_q;
    logic [NU-1:0]    busy, done_v, req, rd1, rd2, dst_en_v;
    logic [NU-1:0][SEQ_W-1:0] seq_v;
    logic [REG_W-1:0] dst_a [NU];
    logic [REG_W-1:0] src1_a [NU];
    logic [REG_W-1:0] src2_a [NU];
    logic [TAG_W-1:0] t1_new, t2_new, waw_tag, new_tag;
    logic             war_blk;

    // Write-after-read hold: finished units wait for untagged readers
    always_comb begin
        for (int u = 0; u < NU; u++) begin
            war_blk = 1'b0;
            for (int j = 0; j < NU; j++) begin
                if (rd1[j] && src1_a[j] == dst_a[u]) war_blk = 1'b1;
                if (rd2[j] && src2_a[j] == dst_a[u]) war_blk = 1'b1;
            end
            wb_en[u] = done_v[u] && !(dst_en_v[u] && war_blk);
        end
    end

    // Producer tags seen by dispatch, released by this cycle's writebacks
    always_comb begin
        t1_new  = in_s1_en  ? rstat[in_s1]  : '0;
        t2_new  = in_s2_en  ? rstat[in_s2]  : '0;
        waw_tag = in_dst_en ? rstat[in_dst] : '0;
        for (int k = 0; k < NU; k++) begin
            if (wb_en[k] && t1_new  == TAG_W'(k + 1)) t1_new  = '0;
            if (wb_en[k] && t2_new  == TAG_W'(k + 1)) t2_new  = '0;
            if (wb_en[k] && waw_tag == TAG_W'(k + 1)) waw_tag = '0;
        end
    end

    // Tag of the unit booked by this dispatch
    always_comb begin
        new_tag = '0;
        for (int u = 0; u < NU; u++) begin
            if (in_unit[u]) new_tag = TAG_W'(u + 1);
        end
    end

    ooo_sb_alloc #(.NU(NU)) u_alloc (
        .valid_i (in_valid),
        .cls_i   (op_cls_e'(in_cls)),
        .waw_i   (waw_tag != '0),
        .free_i  (~busy | wb_en),
        .stall_o (in_stall),
        .pick_o  (in_unit)
    );

    ooo_sb_select #(.NU(NU), .SEQ_W(SEQ_W)) u_select (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .seq_i   (seq_v),
        .grant_o (iss_grant)
    );

    for (genvar u = 0; u < NU; u++) begin : g_unit
        localparam int LAT = (unit_class(u) == CLS_FP) ? FP_LAT : INT_LAT;
        ooo_sb_entry #(
            .REG_W(REG_W), .TAG_W(TAG_W), .SEQ_W(SEQ_W),
            .NU(NU), .LAT(LAT), .MY_IDX(u)
        ) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc_i  (in_unit[u]),
            .dst_en_i (in_dst_en),
            .dst_i    (in_dst),
            .s1_en_i  (in_s1_en),
            .s1_i     (in_s1),
            .t1_i     (t1_new),
            .s2_en_i  (in_s2_en),
            .s2_i     (in_s2),
            .t2_i     (t2_new),
            .seq_i    (seq_q),
            .grant_i  (iss_grant[u]),
            .wb_vec_i (wb_en),
            .busy_o   (busy[u]),
            .done_o   (done_v[u]),
            .req_o    (req[u]),
            .exec_o   (ex_start[u]),
            .dst_en_o (dst_en_v[u]),
            .dst_o    (dst_a[u]),
            .rd1_o    (rd1[u]),
            .src1_o   (src1_a[u]),
            .rd2_o    (rd2[u]),
            .src2_o   (src2_a[u]),
            .seq_o    (seq_v[u])
        );
    end

    // Register producer table: writeback clears, dispatch claims (dispatch wins)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) rstat[r] <= '0;
        end else begin
            for (int k = 0; k < NU; k++) begin
                if (wb_en[k] && dst_en_v[k]) rstat[dst_a[k]] <= '0;
            end
            if ((|in_unit) && in_dst_en) rstat[in_dst] <= new_tag;
        end
    end

    // Dispatch age counter, one step per accepted instruction
    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else if (|in_unit) seq_q <= seq_q + SEQ_W'(1);
    end

    // R7
    alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_unit & busy & ~wb_en) == '0);

    // R2
    stall_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_stall |-> in_valid);

endmodule

// File: tb/ooo_scoreboard_bench.sv
// Scenario bench: the driver queues the expected stage cycles, and a monitor
// matches each observed event against that queue.
module ooo_scoreboard_bench;

    localparam int NU = 5;

    typedef struct {
        int    id;
        int    stg;
        int    cyc;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] in_cls = '0;
    logic       in_dst_en = 1'b0;
    logic [3:0] in_dst = '0;
    logic       in_s1_en = 1'b0;
    logic [3:0] in_s1 = '0;
    logic       in_s2_en = 1'b0;
    logic [3:0] in_s2 = '0;
    logic          in_stall;
    logic [NU-1:0] in_unit, iss_grant, ex_start, wb_en;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc = 0;
    int   base = 0;
    int   cur_id = -1;
    int   unit_id [NU];
    bit   finished = 1'b0;

    ooo_scoreboard u_ooo_scoreboard (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
        .in_dst_en(in_dst_en), .in_dst(in_dst), .in_s1_en(in_s1_en), .in_s1(in_s1),
        .in_s2_en(in_s2_en), .in_s2(in_s2), .in_stall(in_stall), .in_unit(in_unit),
        .iss_grant(iss_grant), .ex_start(ex_start), .wb_en(wb_en)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Queue the four stage cycles (relative to the scenario start) of one instruction
    task automatic expect4(int id, int d, int s, int x, int w, string rq);
        q.push_back('{id, 0, base + d - 1, rq});
        q.push_back('{id, 1, base + s - 1, rq});
        q.push_back('{id, 2, base + x - 1, rq});
        q.push_back('{id, 3, base + w - 1, rq});
    endtask

    task automatic expect_stall(int id, int c, string rq);
        q.push_back('{id, 4, base + c - 1, rq});
    endtask

    // Match one observed event against the queue
    task automatic observe(int id, int stg);
        int  hit = -1;
        string rq;
        for (int i = 0; i < q.size(); i++) begin
            if (hit < 0 && q[i].id == id && q[i].stg == stg && (stg != 4 || q[i].cyc == cyc)) hit = i;
        end
        n_chk++;
        if (hit < 0) begin
            n_bad++;
            case (stg)
                1, 2:    rq = "R4";
                3:       rq = "R9";
                default: rq = "R2";
            endcase
            $display("FAIL %s id=%0d stage=%0d unexpected: actual cycle=%0d expected none", rq, id, stg, cyc);
        end else begin
            if (q[hit].cyc != cyc) begin
                n_bad++;
                $display("FAIL %s id=%0d stage=%0d actual cycle=%0d expected cycle=%0d",
                         q[hit].req, id, stg, cyc, q[hit].cyc);
            end
            q.delete(hit);
        end
    endtask

    // Monitor: grants, execute starts and writebacks first, then dispatch
    always @(negedge clk) begin
        if (rst_n) begin
            for (int u = 0; u < NU; u++) begin
                if (iss_grant[u]) observe(unit_id[u], 1);
                if (ex_start[u])  observe(unit_id[u], 2);
                if (wb_en[u])     observe(unit_id[u], 3);
            end
            if (in_valid) begin
                if (in_stall) observe(cur_id, 4);
                else begin
                    for (int u = 0; u < NU; u++) begin
                        if (in_unit[u]) begin
                            observe(cur_id, 0);
                            unit_id[u] = cur_id;
                        end
                    end
                end
            end
        end
    end

    // Present one instruction and hold it until accepted
    task automatic send(int id, logic [1:0] cls, logic de, logic [3:0] d,
                        logic e1, logic [3:0] a1, logic e2, logic [3:0] a2);
        in_valid = 1'b1; in_cls = cls; in_dst_en = de; in_dst = d;
        in_s1_en = e1; in_s1 = a1; in_s2_en = e2; in_s2 = a2; cur_id = id;
        do @(negedge clk); while (in_stall);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic start_scenario();
        @(posedge clk); #1;
        base = cyc;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    // Register numbers and class codes
    localparam logic [3:0] R1 = 4'd1, R3 = 4'd3, F0 = 4'd8, F1 = 4'd9, F2 = 4'd10;
    localparam logic [3:0] F3 = 4'd11, F4 = 4'd12, F5 = 4'd13, F6 = 4'd14;
    localparam logic [1:0] C_ALU = 2'd0, C_LD = 2'd1, C_ST = 2'd2, C_FP = 2'd3;

    initial begin
        for (int u = 0; u < NU; u++) unit_id[u] = -1;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        n_chk++;
        if (iss_grant != '0 || ex_start != '0 || wb_en != '0 || in_stall != 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset outputs actual grant=%b exec=%b wb=%b stall=%b expected all zero",
                     iss_grant, ex_start, wb_en, in_stall);
        end

        // Two-iteration loop: load, multiply, store, add, load, multiply, store
        start_scenario();
        expect4(0, 1, 2, 3, 4, "R1");
        expect4(1, 2, 4, 5, 8, "R6 R9");
        expect4(2, 3, 8, 9, 10, "R6");
        expect4(3, 4, 5, 6, 9, "R5");
        expect4(4, 5, 9, 10, 11, "R4");
        expect4(5, 8, 11, 12, 15, "R3 R7");
        expect4(6, 10, 15, 16, 17, "R2 R7");
        expect_stall(5, 6, "R3");
        expect_stall(5, 7, "R3");
        expect_stall(6, 9, "R2");
        send(0, C_LD,  1, F1, 1, R1, 0, 4'd0);
        send(1, C_FP,  1, F2, 1, F0, 1, F1);
        send(2, C_ST,  0, 4'd0, 1, F2, 1, R1);
        send(3, C_ALU, 1, R1, 1, R1, 0, 4'd0);
        send(4, C_LD,  1, F1, 1, R1, 0, 4'd0);
        send(5, C_FP,  1, F2, 1, F0, 1, F1);
        send(6, C_ST,  0, 4'd0, 1, F2, 1, R1);
        idle(14);

        // R8: two instructions made ready by one writeback; the older one is on the higher unit
        start_scenario();
        expect4(10, 1, 2, 3, 4, "R4");
        expect4(11, 2, 4, 5, 8, "R8");
        expect4(12, 3, 5, 6, 7, "R8");
        send(10, C_LD,  1, F1, 1, R1, 0, 4'd0);
        send(11, C_FP,  1, F5, 1, F0, 1, F1);
        send(12, C_ALU, 1, R3, 1, F1, 0, 4'd0);
        idle(10);

        // Both floating-point units busy, third one waits for a free unit
        start_scenario();
        expect4(20, 1, 2, 3, 6, "R9");
        expect4(21, 2, 3, 4, 7, "R2");
        expect4(22, 6, 7, 8, 11, "R7");
        expect_stall(22, 3, "R2");
        expect_stall(22, 4, "R2");
        expect_stall(22, 5, "R2");
        send(20, C_FP, 1, F3, 1, F0, 1, F0);
        send(21, C_FP, 1, F4, 1, F0, 1, F0);
        send(22, C_FP, 1, F6, 1, F0, 1, F0);
        idle(12);

        foreach (q[i]) begin
            n_chk++;
            n_bad++;
            $display("FAIL %s id=%0d stage=%0d actual cycle=none expected cycle=%0d",
                     q[i].req, q[i].id, q[i].stg, q[i].cyc);
        end
        finished = 1'b1;
        summary();
        $finish;
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog actual=hung expected=completion");
            summary();
            $finish;
        end
    end

endmodule